// File: doc/BRIEF.md
# Configurable UART frame transmitter

The block turns one parallel character into one asynchronous serial frame on a single output line. A frame is a low start bit, then 7 or 8 data bits sent least significant first, then an optional parity bit, then one or two high stop bits. The line rests high between frames. The parity bit is in one of four modes: absent, always 0, odd or even. The bit period is 16 pulses of a baud tick that an external divider supplies.

A small control register holds a power bit, a transmit-enable bit, a receive-enable bit and three framing fields. Characters arrive on a valid/ready handshake. The handshake accepts a character only while the unit is powered, transmit is enabled and no frame is in flight. Each frame is built from the framing fields that stand at the moment of acceptance. A busy output stays high for the whole frame. The framing fields are locked while the unit is powered with either direction enabled. Dropping power abandons any frame in progress at once.

Top module: `uart_tx_top`

## Requirements
- R1: The parity select `cfg_par` chooses how the parity bit is sent. 2'b00 sends no parity bit. 2'b01 always sends a 0 parity bit. 2'b10 sends odd parity, so the data bits and the parity bit together hold an odd number of ones. 2'b11 sends even parity. Odd and even parity are computed over the configured data bits only.
- R2: With `cfg_len8` = 0 the frame carries 7 data bits, and bit 7 of `tx_data` does not appear in the frame or in the parity. With `cfg_len8` = 1 it carries 8 data bits.
- R3: `cfg_stop2` = 0 sends one stop bit and `cfg_stop2` = 1 sends two stop bits.
- R4: A `cfg_wr` pulse always loads the power and enable bits. It loads the parity, length and stop fields only if, before the write, the stored power bit is 0 or both stored enable bits are 0. Otherwise those three fields keep their values.
- R5: The line is high while idle. A frame is a low start bit, then the data bits least significant first, then the parity bit if there is one, then high stop bits.
- R6: Every bit lasts exactly 16 `baud_tick` pulses. `tx_busy` rises in the cycle after acceptance and falls at the end of the last stop bit, and only then can a new frame start.
- R7: `tx_ready` is high only when the stored power and transmit-enable bits are both 1 and `tx_busy` is 0. A character is taken only when `tx_valid` and `tx_ready` are both high at a clock edge.
- R8: Once the stored power bit is 0, `tx_busy` is 0 and `tx_line` is high from the next cycle on, and any frame in flight is dropped.
- R9: After reset all control bits are 0, `tx_line` is 1, and `tx_busy` and `tx_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_pwr | input | 1 | Power bit value to write |
| cfg_txen | input | 1 | Transmit-enable value to write |
| cfg_rxen | input | 1 | Receive-enable value to write |
| cfg_par | input | 2 | Parity select value to write |
| cfg_len8 | input | 1 | Character length value to write (1 = 8 bits) |
| cfg_stop2 | input | 1 | Stop length value to write (1 = two stop bits) |
| baud_tick | input | 1 | One pulse per sixteenth of a bit period |
| tx_data | input | 8 | Character to send |
| tx_valid | input | 1 | Character offered |
| tx_ready | output | 1 | Character can be taken |
| tx_line | output | 1 | Serial output, high when idle |
| tx_busy | output | 1 | Frame in flight |

## Verification
Characters are sent in each of the four parity modes. A character with bit 7 set is sent in 7-bit mode; a design that leaked that bit would show a wrong data field or a flipped parity bit. Frames with two stop bits are timed to the exact end of busy; a design with a miscounted bit length or stop count fails that timing. Framing writes are tried while the unit is locked by transmit enable and by receive enable alone, and a design that obeyed them would change the next frame. Power is cut in mid-frame, and a design that finished the frame would keep busy high. A character is offered with transmit disabled, and a design that took it would drive a start bit.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int DATA_W  = 8;
    localparam int OVS     = 16;
    localparam int FRAME_W = DATA_W + 4;
    localparam int NB_W    = $clog2(FRAME_W + 1);
    localparam int CNT_W   = $clog2(OVS);

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_ZERO = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_EVEN = 2'b11
    } par_mode_t;

    typedef struct packed {
        logic      pwr;
        logic      txen;
        logic      rxen;
        par_mode_t par;
        logic      len8;
        logic      stop2;
    } tx_cfg_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [NB_W-1:0]    nbits;
    } frame_t;

    function automatic logic [DATA_W-1:0] data_mask(input logic len8);
        data_mask = len8 ? '1 : {1'b0, {(DATA_W-1){1'b1}}};
    endfunction

    function automatic logic parity_bit(input par_mode_t mode,
                                        input logic [DATA_W-1:0] d);
        case (mode)
            PAR_ODD:  parity_bit = ~(^d);
            PAR_EVEN: parity_bit = ^d;
            default:  parity_bit = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/uart_tx_cfg.sv
module uart_tx_cfg
    import uart_tx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr,
    input  tx_cfg_t wdata,
    output tx_cfg_t cfg_q
);
    logic locked;

    assign locked = cfg_q.pwr && (cfg_q.txen || cfg_q.rxen);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr) begin
            cfg_q.pwr  <= wdata.pwr;
            cfg_q.txen <= wdata.txen;
            cfg_q.rxen <= wdata.rxen;
            if (!locked) begin
                cfg_q.par   <= wdata.par;
                cfg_q.len8  <= wdata.len8;
                cfg_q.stop2 <= wdata.stop2;
            end
        end
    end

    assert_cfg_lock_R4: assert property (@(posedge clk) disable iff (rst)
        (wr && cfg_q.pwr && (cfg_q.txen || cfg_q.rxen)) |=>
            ($stable(cfg_q.par) && $stable(cfg_q.len8) && $stable(cfg_q.stop2)));

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
    import uart_tx_pkg::*;
(
    input  tx_cfg_t           cfg,
    input  logic [DATA_W-1:0] data,
    output frame_t            frame
);
    logic [DATA_W-1:0] dmask;
    logic [DATA_W-1:0] dval;
    logic              has_par;
    int                dlen;
    int                total;

    assign dmask   = data_mask(cfg.len8);
    assign dval    = data & dmask;
    assign has_par = (cfg.par != PAR_NONE);

    always_comb begin
        dlen  = cfg.len8 ? DATA_W : DATA_W - 1;
        total = 1 + dlen + (has_par ? 1 : 0) + (cfg.stop2 ? 2 : 1);
        frame.bits    = '1;
        frame.bits[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < dlen) frame.bits[1 + i] = dval[i];
        end
        if (has_par) frame.bits[1 + dlen] = parity_bit(cfg.par, dval);
        frame.nbits = NB_W'(total);
    end

    always_comb begin
        assert_frame_len_R3: assert (frame.nbits >= NB_W'(DATA_W + 1) &&
                                     frame.nbits <= NB_W'(FRAME_W));
    end

endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
    import uart_tx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pwr,
    input  logic   tick,
    input  logic   load,
    input  frame_t frame,
    output logic   busy,
    output logic   line
);
    logic [FRAME_W-1:0] shreg;
    logic [NB_W-1:0]    left;
    logic [CNT_W-1:0]   cnt;

    always_ff @(posedge clk) begin
        if (rst || !pwr) begin
            shreg <= '1;
            left  <= '0;
            cnt   <= '0;
            busy  <= 1'b0;
            line  <= 1'b1;
        end else if (load && !busy) begin
            shreg <= frame.bits;
            left  <= frame.nbits;
            cnt   <= '0;
            busy  <= 1'b1;
            line  <= frame.bits[0];
        end else if (busy && tick) begin
            if (cnt == CNT_W'(OVS - 1)) begin
                cnt <= '0;
                if (left == NB_W'(1)) begin
                    busy <= 1'b0;
                    line <= 1'b1;
                end else begin
                    shreg <= {1'b1, shreg[FRAME_W-1:1]};
                    line  <= shreg[1];
                    left  <= left - NB_W'(1);
                end
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    assert_idle_high_R5: assert property (@(posedge clk) disable iff (rst)
        !busy |-> line);

    assert_bit_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick && pwr) |=> $stable(line));

    assert_power_abort_R8: assert property (@(posedge clk) disable iff (rst)
        !pwr |=> (!busy && line));

endmodule

// File: rtl/uart_tx_top.sv
module uart_tx_top
    import uart_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_wr,
    input  logic       cfg_pwr,
    input  logic       cfg_txen,
    input  logic       cfg_rxen,
    input  logic [1:0] cfg_par,
    input  logic       cfg_len8,
    input  logic       cfg_stop2,
    input  logic       baud_tick,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_ready,
    output logic       tx_line,
    output logic       tx_busy
);
    tx_cfg_t wcfg;
    tx_cfg_t cfg_q;
    frame_t  frame;
    logic    accept;

    always_comb begin
        wcfg.pwr   = cfg_pwr;
        wcfg.txen  = cfg_txen;
        wcfg.rxen  = cfg_rxen;
        wcfg.par   = par_mode_t'(cfg_par);
        wcfg.len8  = cfg_len8;
        wcfg.stop2 = cfg_stop2;
    end

    uart_tx_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_wr),
        .wdata (wcfg),
        .cfg_q (cfg_q)
    );

    uart_tx_framer u_framer (
        .cfg   (cfg_q),
        .data  (tx_data),
        .frame (frame)
    );

    assign tx_ready = cfg_q.pwr && cfg_q.txen && !tx_busy;
    assign accept   = tx_valid && tx_ready;

    uart_tx_engine u_engine (
        .clk   (clk),
        .rst   (rst),
        .pwr   (cfg_q.pwr),
        .tick  (baud_tick),
        .load  (accept),
        .frame (frame),
        .busy  (tx_busy),
        .line  (tx_line)
    );

    assert_accept_gate_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_busy) |-> $past(cfg_q.pwr && cfg_q.txen && tx_valid));

endmodule

// File: tb/tb_uart_tx_top.sv
module tb_uart_tx_top;

    typedef struct {
        logic [11:0] bits;
        int          n;
        string       tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0, cfg_pwr = 1'b0, cfg_txen = 1'b0, cfg_rxen = 1'b0;
    logic [1:0] cfg_par = 2'b00;
    logic       cfg_len8 = 1'b0, cfg_stop2 = 1'b0;
    logic       baud_tick = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready, tx_line, tx_busy;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    bit mon_en  = 1;
    int div     = 0;

    item_t q[$];
    item_t cur;
    bit    in_frame = 0;
    bit    pend_end = 0;
    int    tcount   = 0;
    logic [11:0] got;

    logic [1:0] b_par;
    logic       b_len8, b_stop2;

    uart_tx_top dut (.*);

    always #10 clk = ~clk;

    always @(posedge clk) begin
        div       <= (div == 2) ? 0 : div + 1;
        baud_tick <= (div == 2);
    end

    task automatic check(input bit ok, input string tag, input string msg);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    function automatic item_t expect_frame(input logic [7:0] d, input string tag);
        item_t it;
        int    k = 0;
        int    ones = 0;
        int    dl = b_len8 ? 8 : 7;
        it.bits = '1;
        it.bits[k++] = 1'b0;
        for (int i = 0; i < dl; i++) begin
            it.bits[k++] = d[i];
            if (d[i]) ones++;
        end
        if (b_par == 2'b01) it.bits[k++] = 1'b0;
        else if (b_par == 2'b10) it.bits[k++] = (ones % 2 == 0);
        else if (b_par == 2'b11) it.bits[k++] = (ones % 2 == 1);
        k += b_stop2 ? 2 : 1;
        it.n   = k;
        it.tag = tag;
        return it;
    endfunction

    task automatic cfg_write(input logic p, input logic t, input logic r,
                             input logic [1:0] par, input logic l8, input logic s2);
        @(negedge clk);
        cfg_pwr = p; cfg_txen = t; cfg_rxen = r;
        cfg_par = par; cfg_len8 = l8; cfg_stop2 = s2;
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic set_frame(input logic [1:0] par, input logic l8, input logic s2);
        cfg_write(1'b0, 1'b0, 1'b0, par, l8, s2);
        cfg_write(1'b0, 1'b0, 1'b0, par, l8, s2);
        cfg_write(1'b1, 1'b1, 1'b0, par, l8, s2);
        b_par = par; b_len8 = l8; b_stop2 = s2;
    endtask

    task automatic send(input logic [7:0] d, input string tag, input bit push);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        if (push) q.push_back(expect_frame(d, tag));
        tx_data  = d;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        check(tx_busy && !tx_ready, "R7",
              $sformatf("busy/ready after accept actual %0b/%0b expected 1/0",
                        tx_busy, tx_ready));
    endtask

    task automatic wait_idle();
        while (tx_busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // monitor: samples each bit at its centre and times the end of busy
    always @(negedge clk) begin
        if (!mon_en) begin
            in_frame = 0;
            pend_end = 0;
        end else begin
            if (pend_end) begin
                pend_end = 0;
                check(!tx_busy && tx_line, "R6",
                      $sformatf("%s end of frame busy/line actual %0b/%0b expected 0/1",
                                cur.tag, tx_busy, tx_line));
                for (int i = cur.n; i < 12; i++) got[i] = 1'b1;
                check(got == cur.bits, cur.tag,
                      $sformatf("frame bits actual %012b expected %012b", got, cur.bits));
            end else if (!in_frame && !tx_line && tx_busy) begin
                if (q.size() > 0) begin
                    cur      = q.pop_front();
                    in_frame = 1;
                    tcount   = 0;
                    got      = '1;
                end else begin
                    check(1'b0, "R7", "frame started with nothing expected actual 1 expected 0");
                    in_frame = 0;
                end
            end
            if (in_frame && baud_tick) begin
                if (tcount % 16 == 8) got[tcount / 16] = tx_line;
                if (tcount % 16 == 15 && tcount / 16 < cur.n - 1)
                    if (!tx_busy) check(1'b0, "R6", "busy dropped early actual 0 expected 1");
                tcount++;
                if (tcount == cur.n * 16) begin
                    in_frame = 0;
                    pend_end = 1;
                end
            end
        end
    end

    initial begin
        #4000000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run hung actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        b_par = 2'b00; b_len8 = 1'b0; b_stop2 = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(tx_line && !tx_busy && !tx_ready, "R9",
              $sformatf("reset line/busy/ready actual %0b/%0b/%0b expected 1/0/0",
                        tx_line, tx_busy, tx_ready));

        // R5: plain 8N1 frame
        cfg_write(1'b1, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0);
        b_par = 2'b00; b_len8 = 1'b1; b_stop2 = 1'b0;
        send(8'hA5, "R5", 1); wait_idle();
        send(8'h01, "R5", 1); wait_idle();

        // R1: the parity modes
        set_frame(2'b11, 1'b1, 1'b0); send(8'hA5, "R1", 1); wait_idle();
        set_frame(2'b11, 1'b1, 1'b0); send(8'h07, "R1", 1); wait_idle();
        set_frame(2'b10, 1'b1, 1'b0); send(8'h3C, "R1", 1); wait_idle();
        set_frame(2'b10, 1'b1, 1'b0); send(8'h08, "R1", 1); wait_idle();
        set_frame(2'b01, 1'b1, 1'b0); send(8'hFF, "R1", 1); wait_idle();

        // R2: 7-bit mode ignores bit 7, including in parity
        set_frame(2'b11, 1'b0, 1'b0); send(8'hD3, "R2", 1); wait_idle();
        set_frame(2'b10, 1'b0, 1'b1); send(8'h80, "R2", 1); wait_idle();

        // R3: two stop bits
        set_frame(2'b00, 1'b1, 1'b1); send(8'h5A, "R3", 1); wait_idle();

        // R4: framing writes ignored while locked by transmit enable
        set_frame(2'b00, 1'b1, 1'b0);
        cfg_write(1'b1, 1'b1, 1'b0, 2'b11, 1'b0, 1'b1);
        send(8'h96, "R4", 1); wait_idle();
        // locked by receive enable alone
        cfg_write(1'b1, 1'b0, 1'b1, 2'b10, 1'b0, 1'b1);
        cfg_write(1'b1, 1'b1, 1'b0, 2'b10, 1'b0, 1'b1);
        send(8'h69, "R4", 1); wait_idle();

        // R7: no acceptance with transmit disabled
        cfg_write(1'b1, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0);
        @(negedge clk);
        check(!tx_ready, "R7", $sformatf("ready with txen 0 actual %0b expected 0", tx_ready));
        tx_data = 8'h00; tx_valid = 1'b1;
        begin
            bit low_seen = 0;
            repeat (20) begin
                @(negedge clk);
                if (!tx_line || tx_busy) low_seen = 1;
            end
            tx_valid = 1'b0;
            check(!low_seen, "R7", $sformatf("frame while disabled actual %0b expected 0", low_seen));
        end

        // R8: power drop mid-frame
        cfg_write(1'b1, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0);
        mon_en = 0;
        send(8'h00, "R8", 0);
        repeat (100) @(negedge clk);
        check(tx_busy && !tx_line, "R8",
              $sformatf("mid-frame busy/line actual %0b/%0b expected 1/0", tx_busy, tx_line));
        cfg_write(1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0);
        @(negedge clk);
        check(!tx_busy && tx_line && !tx_ready, "R8",
              $sformatf("after power off busy/line/ready actual %0b/%0b/%0b expected 0/1/0",
                        tx_busy, tx_line, tx_ready));
        repeat (200) @(negedge clk);
        check(!tx_busy && tx_line, "R8",
              $sformatf("held after power off busy/line actual %0b/%0b expected 0/1",
                        tx_busy, tx_line));
        mon_en = 1;

        // recovery after power back on
        cfg_write(1'b1, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0);
        b_par = 2'b00; b_len8 = 1'b1; b_stop2 = 1'b0;
        send(8'hC3, "R5", 1); wait_idle();

        check(q.size() == 0, "R5", $sformatf("frames unseen actual %0d expected 0", q.size()));
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule